// File: doc/BRIEF.md
# Programmable Periodic Interrupt Generator

This block turns a 32768 Hz tick enable into a periodic event whose rate is picked by a 4-bit rate code. A free-running 16-bit count advances on each tick. An event fires on the tick that brings this count to a whole multiple of the selected period. The phase of the events is therefore fixed by the running count, and writing the controls does not restart it.

Each event produces up to three one-cycle strobes. The flag-set strobe is meant for a status register. The interrupt-set strobe is meant for the summary interrupt bit and the request line. The pulse is meant for a square-wave style output. The surrounding register logic drives the rate code and the two enables, and consumes the strobes.

Top module: `periodic_irq_gen`

## Requirements
- R1: After reset all three outputs are low and the running tick count is zero.
- R2: A rate code of 0 stops the generator, so no output ever pulses.
- R3: When both the interrupt enable and the pulse enable are low, no output pulses, including the flag-set strobe.
- R4: For rate codes 3 through 15 the period is 2^(code-1) ticks. Code 3 gives 4 ticks and code 15 gives 16384 ticks.
- R5: Code 1 behaves as code 8 (128 ticks) and code 2 behaves as code 9 (256 ticks).
- R6: An event occurs on a tick exactly when the tick count after that tick's increment is a multiple of the period. The count is the number of ticks since reset, modulo 2^16.
- R7: Every event pulses `flag_set`.
- R8: `irq_set` pulses on an event only while `pie_en` is high.
- R9: `sqw_pulse` pulses on an event only while `sqw_en` is high.
- R10: Outputs are registered one-cycle pulses. They appear in the clock cycle after the edge that samples the tick, and never without a tick.
- R11: A change of the rate code or of an enable is acted on at the next tick only. A change made while no tick is present produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_32k | input | 1 | One-cycle enable at 32768 Hz |
| rate_code | input | 4 | Rate selection code |
| pie_en | input | 1 | Periodic interrupt enable |
| sqw_en | input | 1 | Square-wave pulse enable |
| flag_set | output | 1 | Periodic flag set strobe |
| irq_set | output | 1 | Interrupt flag and request set strobe |
| sqw_pulse | output | 1 | Square-wave output pulse |

## Verification
The bench sweeps every rate code under a continuous tick and runs each for just over two periods. This separates the power-of-two mapping from the aliasing of codes 1 and 2, and the spacing between pulses confirms the period itself. Runs with only one enable set distinguish the flag strobe from the interrupt and pulse strobes. Zero-code and both-disabled runs confirm that the generator stays silent. A sparse tick pattern, together with control changes made while no tick is present, shows that events follow the tick count rather than clock cycles or control writes. Since the running count is never cleared between runs, later runs begin at arbitrary phases. This exercises the alignment to multiples of the period.

// File: rtl/pig_pkg.sv
package pig_pkg;
  localparam int CODE_W = 4;

  // Exponent of the period for a nonzero rate code; codes 1 and 2 fold onto 8 and 9.
  function automatic int unsigned rate_exp(input logic [CODE_W-1:0] code);
    if (code == 4'd1 || code == 4'd2) return int'(code) + 6;
    return int'(code) - 1;
  endfunction

  // Low-bit mask of the running count for a given exponent.
  function automatic logic [15:0] exp_mask(input int unsigned e);
    logic [16:0] one_hot;
    one_hot = 17'd1 << e;
    return one_hot[15:0] - 16'd1;
  endfunction
endpackage

// File: rtl/pig_rate_decode.sv
module pig_rate_decode
  import pig_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [CODE_W-1:0] rate_code,
  input  logic              pie_en,
  input  logic              sqw_en,
  output logic [CNT_W-1:0]  bound_mask,
  output logic              gen_active
);
  logic [15:0] full_mask;

  always_comb begin
    full_mask  = exp_mask(rate_exp(rate_code));
    bound_mask = full_mask[CNT_W-1:0];
    gen_active = (rate_code != '0) && (pie_en || sqw_en);
  end
endmodule

// File: rtl/pig_tick_counter.sv
module pig_tick_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] count_next
);
  assign count_next = count + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (tick) count <= count_next;
  end
endmodule

// File: rtl/pig_event_gen.sv
module pig_event_gen #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             gen_active,
  input  logic [CNT_W-1:0] bound_mask,
  input  logic [CNT_W-1:0] count_next,
  input  logic             pie_en,
  input  logic             sqw_en,
  output logic             boundary_hit,
  output logic             flag_set,
  output logic             irq_set,
  output logic             sqw_pulse
);
  assign boundary_hit = tick && gen_active && ((count_next & bound_mask) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_set  <= 1'b0;
      irq_set   <= 1'b0;
      sqw_pulse <= 1'b0;
    end else begin
      flag_set  <= boundary_hit;
      irq_set   <= boundary_hit && pie_en;
      sqw_pulse <= boundary_hit && sqw_en;
    end
  end
endmodule

// File: rtl/periodic_irq_gen.sv
module periodic_irq_gen
  import pig_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_32k,
  input  logic [CODE_W-1:0] rate_code,
  input  logic              pie_en,
  input  logic              sqw_en,
  output logic              flag_set,
  output logic              irq_set,
  output logic              sqw_pulse
);
  logic [CNT_W-1:0] bound_mask;
  logic             gen_active;
  logic [CNT_W-1:0] tick_cnt;
  logic [CNT_W-1:0] tick_cnt_next;
  logic             boundary_hit;

  pig_rate_decode #(.CNT_W(CNT_W)) u_dec (
    .rate_code (rate_code),
    .pie_en    (pie_en),
    .sqw_en    (sqw_en),
    .bound_mask(bound_mask),
    .gen_active(gen_active)
  );

  pig_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick_32k),
    .count     (tick_cnt),
    .count_next(tick_cnt_next)
  );

  pig_event_gen #(.CNT_W(CNT_W)) u_evt (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick_32k),
    .gen_active  (gen_active),
    .bound_mask  (bound_mask),
    .count_next  (tick_cnt_next),
    .pie_en      (pie_en),
    .sqw_en      (sqw_en),
    .boundary_hit(boundary_hit),
    .flag_set    (flag_set),
    .irq_set     (irq_set),
    .sqw_pulse   (sqw_pulse)
  );
endmodule

// File: rtl/pig_checks.sv
module pig_checks #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_32k,
  input logic [3:0]       rate_code,
  input logic             pie_en,
  input logic             sqw_en,
  input logic [CNT_W-1:0] tick_cnt,
  input logic             flag_set,
  input logic             irq_set,
  input logic             sqw_pulse
);
  // R2
  zero_code_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set |-> $past(rate_code) != 4'd0);

  // R3
  needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set |-> ($past(pie_en) || $past(sqw_en)));

  // R6
  aligned_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set |-> tick_cnt[1:0] == 2'b00);

  // R8
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |-> (flag_set && $past(pie_en)));

  // R9
  sqw_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sqw_pulse |-> (flag_set && $past(sqw_en)));

  // R10
  needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set |-> $past(tick_32k));

  // R10
  single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set |=> !flag_set);
endmodule

bind periodic_irq_gen pig_checks #(.CNT_W(CNT_W)) u_pig_checks (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick_32k (tick_32k),
  .rate_code(rate_code),
  .pie_en   (pie_en),
  .sqw_en   (sqw_en),
  .tick_cnt (tick_cnt),
  .flag_set (flag_set),
  .irq_set  (irq_set),
  .sqw_pulse(sqw_pulse)
);

// File: tb/periodic_irq_gen_test.sv
module periodic_irq_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_32k = 1'b0;
  logic [3:0] rate_code = 4'd0;
  logic       pie_en = 1'b0;
  logic       sqw_en = 1'b0;
  logic       flag_set, irq_set, sqw_pulse;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  periodic_irq_gen uut (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .rate_code(rate_code),
    .pie_en(pie_en), .sqw_en(sqw_en),
    .flag_set(flag_set), .irq_set(irq_set), .sqw_pulse(sqw_pulse)
  );

  function automatic int period_of(input logic [3:0] c);
    case (c)
      4'd1:    return 128;
      4'd2:    return 256;
      default: return 2 ** (int'(c) - 1);
    endcase
  endfunction

  // Reference model: counts ticks and decides events by remainder.
  int  m_ticks = 0;
  logic e_flag = 1'b0, e_irq = 1'b0, e_sqw = 1'b0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ticks <= 0;
      e_flag <= 1'b0; e_irq <= 1'b0; e_sqw <= 1'b0;
    end else begin
      logic ev;
      int   nt;
      nt = (m_ticks + (tick_32k ? 1 : 0)) % 65536;
      ev = tick_32k && rate_code != 0 && (pie_en || sqw_en) &&
           (nt % period_of(rate_code) == 0);
      m_ticks <= nt;
      e_flag <= ev;
      e_irq  <= ev && pie_en;
      e_sqw  <= ev && sqw_en;
    end
  end

  task automatic check(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic run_phase(input logic [3:0] code, input logic pie, input logic sqw,
                           input int ncyc, input int tmode, input string tag,
                           input int exp_flags);
    int obs_f = 0, obs_i = 0, obs_s = 0, mod_f = 0;
    int last = -1;
    bit space_ok = 1'b1;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      check(flag_set, e_flag, "R7 flag_set");
      check(irq_set, e_irq, "R8 irq_set");
      check(sqw_pulse, e_sqw, "R9 sqw_pulse");
      if (flag_set) begin
        obs_f++;
        if (tmode == 1 && last >= 0 && (i - last) != period_of(code)) space_ok = 1'b0;
        last = i;
      end
      if (irq_set) obs_i++;
      if (sqw_pulse) obs_s++;
      if (e_flag) mod_f++;
      rate_code = code; pie_en = pie; sqw_en = sqw;
      tick_32k = (tmode == 1) || (tmode == 2 && (i % 3) == 0);
    end
    @(negedge clk);
    check(flag_set, e_flag, "R7 flag_set");
    if (flag_set) obs_f++;
    if (e_flag) mod_f++;
    tick_32k = 1'b0;
    check(obs_f, mod_f, {tag, " event count vs model"});
    if (exp_flags >= 0) check(obs_f, exp_flags, {tag, " event count"});
    check(int'(space_ok), 1, {tag, " spacing"});
    check(obs_i, pie ? obs_f : 0, {tag, " irq count"});
    check(obs_s, sqw ? obs_f : 0, {tag, " sqw count"});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(flag_set, 0, "R1 flag_set reset");
    check(irq_set, 0, "R1 irq_set reset");
    check(sqw_pulse, 0, "R1 sqw_pulse reset");
    rst_n = 1'b1;
    // R2: zero code stays silent
    run_phase(4'd0, 1'b1, 1'b1, 600, 1, "R2", 0);
    // R3: both enables low
    run_phase(4'd3, 1'b0, 1'b0, 100, 1, "R3", 0);
    // R4: all power-of-two codes
    for (int c = 3; c <= 15; c++)
      run_phase(4'(c), 1'b1, 1'b1, 2 * period_of(4'(c)) + 5, 1, "R4", -1);
    // R5: aliased codes
    run_phase(4'd1, 1'b1, 1'b1, 2 * 128 + 5, 1, "R5", -1);
    run_phase(4'd2, 1'b1, 1'b1, 2 * 256 + 5, 1, "R5", -1);
    // R8 / R9: single enables
    run_phase(4'd4, 1'b1, 1'b0, 100, 1, "R8", -1);
    run_phase(4'd4, 1'b0, 1'b1, 100, 1, "R9", -1);
    // R10: sparse ticks, events per tick count not per clock
    run_phase(4'd3, 1'b1, 1'b1, 240, 2, "R10", -1);
    // R11: controls change while no tick is present
    run_phase(4'd3, 1'b1, 1'b1, 20, 0, "R11", 0);
    run_phase(4'd0, 1'b1, 1'b1, 20, 0, "R11", 0);
    // R6: arbitrary starting phase, alignment to count multiples
    run_phase(4'd5, 1'b1, 1'b0, 7, 1, "R6", -1);
    run_phase(4'd6, 1'b0, 1'b1, 200, 1, "R6", -1);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule